// File: doc/BRIEF.md
# I2S Multi-Line Audio Serializer with Pair Routing

This block is the transmit side of a digital audio path acting as clock master on an I2S bus. Tagged PCM samples for eight channels arrive on a simple valid-qualified input: a channel number and a sample word. They are kept in a staging bank. At the start of every audio frame the staging bank is copied into a frame bank. Up to four serial data lines then shift the frame bank out, all sharing one bit clock and one word clock. Both clocks are derived from the audio master clock, which also clocks the block.

Each output line has its own routing register. It selects which stereo pair of the frame bank the line carries, or parks the line at zero. A small register port sets the enable bit, the bit-clock divider, the routing and the interrupt enable. The block counts frames and raises a sticky, write-one-to-clear flag each time a 192-frame audio block has gone out. That flag drives the interrupt output when its enable bit is set.

Top module: `i2s_route_tx`

## Requirements
- R1: After reset, control reads 0, divider reads 4, interrupt enable reads 0, status reads 0, and the routing registers of lines 0..3 read 1, 2, 3, 4. The outputs sck, lrclk, sd and irq are low.
- R2: Bit 0 of the control register (address 0) enables the block, and bits 31:1 read as 0. While the block is disabled, sck, lrclk and every sd line stay low and the counters are held cleared, so each enable starts a fresh frame with its left half.
- R3: The divider register (address 1, 8 bits) sets the bit-clock period to 2*DIV master-clock cycles. A DIV of 0 acts as 1. Every frame holds 64 bit periods.
- R4: lrclk is low during the first 32 bit periods of a frame (left channel) and high during the last 32 (right channel). It changes only when sck falls.
- R5: In each half, the sample goes out MSB first in bit periods 1..16 of that half. Bit period 0 and periods 17..31 carry 0. sd changes only when sck falls, so it is steady while sck is high.
- R6: The routing register of line L (address 4+L, 3 bits) picks the pair: value v from 1 to 4 sends channel 2(v-1) on the left half and channel 2(v-1)+1 on the right half. Values 0, 5, 6 and 7 drive the line low.
- R7: A sample with smp_valid high goes to the staging slot given by smp_chan. A staged value reaches the lines from the next frame start; the frame already running is not changed.
- R8: Status bit 0 (address 3) sets at the end of every 192nd frame since enable. Writing 1 to it clears it and writing 0 leaves it; a new block end wins over a clear in the same cycle.
- R9: irq equals status bit 0 ANDed with interrupt-enable bit 0 (address 2).
- R10: reg_rdata returns the register at reg_addr, combinationally, with unused bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Audio master clock, clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| smp_valid | input | 1 | Sample input valid |
| smp_chan | input | 3 | Channel number of the sample, 0..7 |
| smp_data | input | SW | Sample word |
| sck | output | 1 | Bit clock |
| lrclk | output | 1 | Word clock, low = left |
| sd | output | LINES | Serial data lines |
| irq | output | 1 | Interrupt, status AND enable |

## Verification
The bench samples sd and lrclk on the falling edge of mclk that follows each rising edge of sck. Data and word clock move only on the fall of sck, so the value is then at least half a bit period old and steady. A register write takes effect at the next mclk edge, and reads are combinational, so each read is taken one time step after the address is driven. The reference bank is copied at the mclk edge where lrclk falls, matching the frame-start load. The block flag is checked at the frame start just before the 192nd frame boundary, where it must still be clear, and at the boundary itself, where it must be set.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef logic [2:0] route_t;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_DIV   = 3'd1;
  localparam logic [2:0] ADR_IEN   = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_ROUTE = 3'd4;

  // a route value selects a pair only in the range 1..4
  function automatic logic route_on(input route_t r);
    return (r >= 3'd1) && (r <= 3'd4);
  endfunction

  function automatic logic [1:0] route_pair(input route_t r);
    return 2'(r - 3'd1);
  endfunction

  // reset route of line l is l+1
  function automatic route_t route_reset(input int l);
    return route_t'(l + 1);
  endfunction
endpackage

// File: rtl/ptx_regs.sv
module ptx_regs
  import ptx_pkg::*;
#(
  parameter int LINES = 4,
  parameter int DIVW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  input  logic               blk_done,
  output logic [31:0]        rdata,
  output logic               en,
  output logic [DIVW-1:0]    div,
  output logic               ien,
  output logic               stat,
  output logic [LINES*3-1:0] route_flat
);
  localparam logic [DIVW-1:0] DIV_RESET = DIVW'(4);

  route_t route [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      div <= DIV_RESET;
      ien <= 1'b0;
    end else if (we) begin
      if (addr == ADR_CTRL) en  <= wdata[0];
      if (addr == ADR_DIV)  div <= wdata[DIVW-1:0];
      if (addr == ADR_IEN)  ien <= wdata[0];
    end
  end

  // block end has priority over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  stat <= 1'b0;
    else if (blk_done)                           stat <= 1'b1;
    else if (we && addr == ADR_STAT && wdata[0]) stat <= 1'b0;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 route[l] <= route_reset(l);
      else if (we && addr == ADR_ROUTE + 3'(l))   route[l] <= wdata[2:0];
    end
    assign route_flat[l*3 +: 3] = route[l];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL: rdata = {31'b0, en};
      ADR_DIV:  rdata = 32'(div);
      ADR_IEN:  rdata = {31'b0, ien};
      ADR_STAT: rdata = {31'b0, stat};
      default: begin
        for (int l = 0; l < LINES; l++)
          if (addr == ADR_ROUTE + 3'(l)) rdata = 32'(route[l]);
      end
    endcase
  end
endmodule

// File: rtl/ptx_clkgen.sv
module ptx_clkgen #(
  parameter int DIVW  = 8,
  parameter int SLOT  = 32,
  parameter int BLOCK = 192,
  localparam int BW   = $clog2(2*SLOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            sck,
  output logic            lrclk,
  output logic [BW-1:0]   bitpos,
  output logic            frame_load,
  output logic            blk_done
);
  localparam int CW = DIVW + 1;
  localparam int FW = $clog2(BLOCK);

  // half bit period in master clocks; zero acts as one
  function automatic logic [CW-1:0] half_len(input logic [DIVW-1:0] d);
    return (d == '0) ? CW'(1) : {1'b0, d};
  endfunction

  logic [CW-1:0] hl, last_cnt, cnt, cnt_nx;
  logic [FW-1:0] fcnt;
  logic          bit_end, frame_end;

  assign hl        = half_len(div);
  assign last_cnt  = CW'((hl << 1) - 1'b1);
  assign bit_end   = en && (cnt >= last_cnt);
  assign frame_end = bit_end && (bitpos == {BW{1'b1}});
  assign blk_done  = frame_end && (fcnt == FW'(BLOCK - 1));
  assign cnt_nx    = bit_end ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; bitpos <= '0; fcnt <= '0; sck <= 1'b0;
    end else if (!en) begin
      cnt <= '0; bitpos <= '0; fcnt <= '0; sck <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      sck <= (cnt_nx >= hl);
      if (bit_end) bitpos <= bitpos + 1'b1;
      if (frame_end) fcnt <= blk_done ? '0 : fcnt + 1'b1;
    end
  end

  assign lrclk      = bitpos[BW-1];
  assign frame_load = (cnt == '0) && (bitpos == '0);
endmodule

// File: rtl/ptx_lane.sv
module ptx_lane
  import ptx_pkg::*;
#(
  parameter int SW   = 16,
  parameter int SLOT = 32,
  parameter int NCH  = 8,
  localparam int BW  = $clog2(2*SLOT)
) (
  input  logic [NCH*SW-1:0] bank,
  input  route_t            route,
  input  logic [BW-1:0]     bitpos,
  output logic              sd
);
  // channel feeding this line in the current half
  function automatic int chan_of(input route_t r, input logic right);
    return 2 * int'(route_pair(r)) + int'(right);
  endfunction

  int q;

  always_comb begin
    q  = int'(bitpos[BW-2:0]);
    sd = 1'b0;
    if (route_on(route) && q >= 1 && q <= SW)
      sd = bank[chan_of(route, bitpos[BW-1]) * SW + SW - q];
  end
endmodule

// File: rtl/i2s_route_tx.sv
module i2s_route_tx
  import ptx_pkg::*;
#(
  parameter int LINES = 4,
  parameter int SW    = 16,
  parameter int SLOT  = 32,
  parameter int DIVW  = 8,
  parameter int BLOCK = 192
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             smp_valid,
  input  logic [2:0]       smp_chan,
  input  logic [SW-1:0]    smp_data,
  output logic             sck,
  output logic             lrclk,
  output logic [LINES-1:0] sd,
  output logic             irq
);
  localparam int NCH = 8;
  localparam int BW  = $clog2(2*SLOT);

  logic               en, ien, stat, blk_done, frame_load;
  logic [DIVW-1:0]    div;
  logic [LINES*3-1:0] route_flat;
  logic [BW-1:0]      bitpos;
  logic [SW-1:0]      stage [NCH];
  logic [SW-1:0]      bank  [NCH];
  logic [NCH*SW-1:0]  bank_flat;

  ptx_regs #(.LINES(LINES), .DIVW(DIVW)) u_regs (
    .clk(mclk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .blk_done(blk_done), .rdata(reg_rdata), .en(en), .div(div), .ien(ien),
    .stat(stat), .route_flat(route_flat)
  );

  ptx_clkgen #(.DIVW(DIVW), .SLOT(SLOT), .BLOCK(BLOCK)) u_clk (
    .clk(mclk), .rst_n(rst_n), .en(en), .div(div), .sck(sck), .lrclk(lrclk),
    .bitpos(bitpos), .frame_load(frame_load), .blk_done(blk_done)
  );

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        stage[c] <= '0;
        bank[c]  <= '0;
      end
    end else begin
      if (smp_valid) stage[smp_chan] <= smp_data;
      if (frame_load)
        for (int c = 0; c < NCH; c++) bank[c] <= stage[c];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign bank_flat[c*SW +: SW] = bank[c];
  end

  for (genvar l = 0; l < LINES; l++) begin : g_lane
    ptx_lane #(.SW(SW), .SLOT(SLOT), .NCH(NCH)) u_lane (
      .bank(bank_flat), .route(route_flat[l*3 +: 3]), .bitpos(bitpos), .sd(sd[l])
    );
  end

  assign irq = stat & ien;
endmodule

// File: rtl/ptx_chk.sv
module ptx_chk #(
  parameter int LINES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               sck,
  input logic               lrclk,
  input logic [LINES-1:0]   sd,
  input logic [LINES*3-1:0] route_flat,
  input logic               blk_done,
  input logic               stat,
  input logic               irq
);
  // R2: a disabled block goes quiet one cycle later
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sck && !lrclk && sd == '0));

  // R4: word clock moves only on a bit-clock fall
  a_r4_lr_on_sck_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && lrclk != $past(lrclk)) |-> ($past(sck) && !sck));

  // R5: data steady while the bit clock is high
  a_r5_sd_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sck && $past(sck) && $stable(route_flat)) |-> $stable(sd));

  // R8: block end raises the status flag
  a_r8_block_sets: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> stat);

  // R9: no interrupt without status
  a_r9_irq_needs_stat: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat);

  // R6: a parked line stays low
  for (genvar l = 0; l < LINES; l++) begin : g_off
    a_r6_line_off: assert property (@(posedge clk) disable iff (!rst_n)
      (route_flat[l*3 +: 3] == 3'd0 || route_flat[l*3 +: 3] > 3'd4) |-> !sd[l]);
  end
endmodule

bind i2s_route_tx ptx_chk #(.LINES(LINES)) u_chk (
  .clk(mclk), .rst_n(rst_n), .en(en), .sck(sck), .lrclk(lrclk), .sd(sd),
  .route_flat(route_flat), .blk_done(blk_done), .stat(stat), .irq(irq)
);

// File: tb/sim_i2s_route_tx.sv
module sim_i2s_route_tx;
  localparam int CLK_NS = 10;
  localparam int LINES  = 4;
  localparam int SW     = 16;
  localparam int SLOT   = 32;

  logic             mclk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             smp_valid = 1'b0;
  logic [2:0]       smp_chan = '0;
  logic [SW-1:0]    smp_data = '0;
  logic             sck, lrclk, irq;
  logic [LINES-1:0] sd;

  i2s_route_tx u0 (
    .mclk(mclk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .sck(sck), .lrclk(lrclk),
    .sd(sd), .irq(irq)
  );

  always #(CLK_NS/2) mclk = ~mclk;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  logic [SW-1:0] stage_m [8];
  logic [SW-1:0] bank_m  [8];
  int  route_m [LINES] = '{1, 2, 3, 4};
  int  div_m  = 4;
  bit  mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int exp_sd(input int l, input int p);
    int r    = route_m[l];
    int side = p / SLOT;
    int q    = p % SLOT;
    if (r < 1 || r > 4) return 0;
    if (q < 1 || q > SW) return 0;
    return int'((bank_m[2*(r-1) + side] >> (SW - q)) & 1);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge mclk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge mclk);
    case (a)
      3'd0: mon_on = d[0];
      3'd1: div_m = int'(d[7:0]);
      3'd4, 3'd5, 3'd6, 3'd7: route_m[int'(a) - 4] = int'(d[2:0]);
      default: ;
    endcase
    @(negedge mclk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge mclk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic push(input int ch, input logic [SW-1:0] v);
    @(negedge mclk);
    smp_valid = 1'b1; smp_chan = 3'(ch); smp_data = v;
    @(posedge mclk);
    stage_m[ch] = v;
    @(negedge mclk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_fall();
    logic prev = lrclk;
    forever begin
      @(negedge mclk);
      if (prev && !lrclk) break;
      prev = lrclk;
    end
  endtask

  // serial monitor: samples one negedge after each sck rise
  int pos = 0, cyc = 0;
  bit seen = 1'b0, prev_sck = 1'b0, prev_lr = 1'b0;
  always @(negedge mclk) begin
    if (!mon_on) begin
      pos = 0; cyc = 0; seen = 1'b0;
      for (int c = 0; c < 8; c++) bank_m[c] = stage_m[c];
    end else begin
      cyc++;
      if (prev_lr && !lrclk)
        for (int c = 0; c < 8; c++) bank_m[c] = stage_m[c];   // R7 frame-start copy
      if (sck && !prev_sck) begin
        if (seen) chk(cyc == 2 * (div_m == 0 ? 1 : div_m), "R3 bit period", cyc, 2 * (div_m == 0 ? 1 : div_m));
        seen = 1'b1; cyc = 0;
        chk(lrclk == (pos >= SLOT), "R4 word clock", lrclk, pos >= SLOT);
        for (int l = 0; l < LINES; l++)
          chk(int'(sd[l]) == exp_sd(l, pos), "R5/R6 serial bit", sd[l], exp_sd(l, pos));
        pos = (pos + 1) % (2 * SLOT);
      end
    end
    prev_sck = sck;
    prev_lr  = lrclk;
  end

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 8; c++) stage_m[c] = '0;
    repeat (4) @(negedge mclk);
    rst_n = 1'b1;

    // R1 / R10 reset state
    rd(3'd0, v); chk(v == 0, "R1 control reset", v, 0);
    rd(3'd1, v); chk(v == 4, "R1 divider reset", v, 4);
    rd(3'd2, v); chk(v == 0, "R1 irq enable reset", v, 0);
    rd(3'd3, v); chk(v == 0, "R1 status reset", v, 0);
    for (int l = 0; l < LINES; l++) begin
      rd(3'(4 + l), v); chk(v == 32'(l + 1), "R1 route reset", v, l + 1);
    end
    chk({sck, lrclk, sd, irq} == '0, "R1 outputs low", {sck, lrclk, sd, irq}, 0);

    // R2 reserved bits, no enable from a write with bit 0 clear
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, v); chk(v == 0, "R2 reserved bits read 0", v, 0);
    wr(3'd1, 32'd4);
    rd(3'd1, v); chk(v == 4, "R10 divider readback", v, 4);

    for (int c = 0; c < 8; c++) push(c, 16'(c * 16'h2F1B ^ 16'hA5C3));
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk(v == 1, "R2 enable reads 1 only", v, 1);

    // R6 route sweep: every line sees every value; R7 mid-frame sample updates
    for (int f = 0; f < 8; f++) begin
      wait_fall();
      for (int l = 0; l < LINES; l++) wr(3'(4 + l), 32'((f + l) % 8));
      push(f, 16'(16'h8001 << f ^ 16'h3C00 + f));
      rd(3'(4 + 1), v); chk(v == 32'((f + 1) % 8), "R10 route readback", v, (f + 1) % 8);
    end
    wait_fall();
    wait_fall();

    // R2 quiet while disabled
    wr(3'd0, 32'd0);
    repeat (2) @(negedge mclk);
    for (int i = 0; i < 40; i++) begin
      @(negedge mclk);
      chk({sck, lrclk, sd} == '0, "R2 disabled outputs low", {sck, lrclk, sd}, 0);
    end

    // R3 divider sweep, including 0 acting as 1
    for (int l = 0; l < LINES; l++) wr(3'(4 + l), 32'(4 - l));
    for (int d = 0; d < 4; d++) begin
      wr(3'd1, 32'(d));
      wr(3'd0, 32'd1);
      wait_fall();
      wait_fall();
      wr(3'd0, 32'd0);
      repeat (3) @(negedge mclk);
    end

    // R8 / R9 block flag
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd1);
    wr(3'd0, 32'd1);
    for (int n = 0; n < 191; n++) wait_fall();
    rd(3'd3, v); chk(v == 0, "R8 flag clear before block end", v, 0);
    chk(irq == 1'b0, "R9 irq low before block end", irq, 0);
    wait_fall();
    rd(3'd3, v); chk(v == 1, "R8 flag set at block end", v, 1);
    chk(irq == 1'b1, "R9 irq follows flag", irq, 1);
    wr(3'd2, 32'd0);
    #1 chk(irq == 1'b0, "R9 irq masked", irq, 0);
    wr(3'd3, 32'd0);
    rd(3'd3, v); chk(v == 1, "R8 write 0 keeps flag", v, 1);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd1);
    rd(3'd3, v); chk(v == 0, "R8 write 1 clears flag", v, 0);
    chk(irq == 1'b0, "R9 irq drops with flag", irq, 0);
    wr(3'd0, 32'd0);
    repeat (4) @(negedge mclk);
    finish_up();
  end
endmodule